// File: doc/BRIEF.md
# Loop-End Branch Unit with Tail Predication

This unit resolves the closing instruction of a hardware-counted loop in a small processor core. Decode supplies the instruction's flags, its backward branch distance and the address it sits at. The register file supplies the loop counter. The unit decides whether to branch back to the loop head or fall through, computes the new counter value and the next fetch address, and flags an undefined instruction, an FPU-access fault or an invalid-state usage fault. All results are registered and are valid in the cycle after the request.

The instruction has two forms. The plain form counts down by one per pass, or loops without end when the infinite flag is set. The tail-predicated form counts down by the number of vector elements per beat. That step size comes from an element-size register held inside the unit, and the register returns to its default of 4 when such a loop exits. Other instructions may load the element-size register through a write port.

The unit also has to judge whether the FPU is active. The plain form may only see a non-default element size while the FPU is active, and it faults if it does.

Top module: `loop_end_unit`

## Requirements
- R1: After reset the element-size register reads 4 and `rsp_valid` is low. `rsp_valid` is high exactly in the cycle after each cycle with `req_valid` high, and the response fields are valid in that cycle.
- R2: `rsp_undef` is raised when any of these holds: the loop extension is absent (`lob_present`=0), both `req_forever` and `req_tailpred` are set, `in_cond_block` is set, or `req_tailpred` is set while the vector extension is absent (`vec_present`=0).
- R3: A tail-predicated request that is not undefined raises `rsp_fpu_fault` when `fpu_enabled` is 0.
- R4: At most one fault flag is high per response, with priority undefined over FPU-access over invalid-state. A faulting response has `rsp_taken`=0, `rsp_next_pc` equal to the request PC and `rsp_count` equal to the request count, and it leaves the element-size register unchanged.
- R5: The FPU is active only when `fpu_enabled`=1, `fpu_lazy_pend`=0 and `fpu_new_ctx`=0. While it is inactive, the plain form sees an element size of 4. The tail-predicated form always uses the stored register value.
- R6: A plain-form request raises `rsp_inv_state` when `vec_present`=1, the FPU is active and the stored element size is not 4.
- R7: With `req_forever`=1 and no fault, the branch is taken to request PC minus the zero-extended offset, and the count is returned unchanged.
- R8: Plain form without `req_forever`: a count of 1 or less (unsigned) falls through, with next PC equal to request PC + 4 and the count unchanged. Otherwise the branch is taken and the count drops by 1.
- R9: Tail-predicated form: the step is 1 << (4 − element size), giving 16, 8, 4, 2 or 1 for sizes 0 to 4. A count less than or equal to the step (unsigned) falls through with the count unchanged. Otherwise the branch is taken and the count drops by the step.
- R10: A tail-predicated fall-through writes 4 into the element-size register, visible on `esz_q` in the response cycle.
- R11: `esz_wr_en` loads values 0 to 4 into the element-size register and ignores values 5 to 7. If a tail-predicated exit happens in the same cycle as a write, the exit's reset to 4 wins.
- R12: `esz_q` never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Loop-end instruction presented this cycle |
| req_forever | input | 1 | Infinite-loop form |
| req_tailpred | input | 1 | Tail-predicated form |
| req_offset | input | OFS_W | Backward branch distance |
| req_pc | input | XLEN | Address of the instruction |
| req_count | input | XLEN | Current loop counter |
| lob_present | input | 1 | Loop extension implemented |
| vec_present | input | 1 | Vector extension implemented |
| fpu_enabled | input | 1 | FPU access permitted |
| fpu_lazy_pend | input | 1 | Lazy FP state preservation pending |
| fpu_new_ctx | input | 1 | A new FP context must be created |
| in_cond_block | input | 1 | Instruction sits in a conditional-execution block |
| esz_wr_en | input | 1 | Write strobe for the element-size register |
| esz_wr_data | input | 3 | Value to write |
| esz_q | output | 3 | Current element-size register |
| rsp_valid | output | 1 | Response valid |
| rsp_taken | output | 1 | Branch back to loop head |
| rsp_next_pc | output | XLEN | Next fetch address |
| rsp_count | output | XLEN | Updated loop counter |
| rsp_undef | output | 1 | Undefined-instruction fault |
| rsp_fpu_fault | output | 1 | FPU-access fault |
| rsp_inv_state | output | 1 | Invalid-state usage fault |

## Verification
The bench targets the counter boundaries: a count equal to the step and a count one above it, for each element size. A wrong comparison here would run one extra pass or wrap the counter below zero. It also enables one source of undefinedness at a time, and lets a lower-priority fault coincide with an undefined case, so that a misordered priority would show two flags at once. It checks that a lazy-pending or new-context FPU hides a non-default size from the plain form; a design that read the raw register would raise spurious invalid-state faults. Finally, it collides an element-size write with a tail-predicated exit and writes illegal sizes, which would leave a stale or out-of-range step if handled wrongly.

// File: rtl/loop_end_pkg.sv
package loop_end_pkg;
  localparam int unsigned ESZ_W = 3;
  localparam logic [ESZ_W-1:0] ESZ_DFLT = 3'd4;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_UNDEF = 2'd1,
    FLT_FPU   = 2'd2,
    FLT_INVST = 2'd3
  } flt_e;
endpackage

// File: rtl/loop_end_classify.sv
module loop_end_classify
  import loop_end_pkg::*;
(
  input  logic             forever_i,
  input  logic             tailpred_i,
  input  logic             in_cond_i,
  input  logic             lob_i,
  input  logic             vec_i,
  input  logic             fpu_en_i,
  input  logic             lazy_i,
  input  logic             newctx_i,
  input  logic [ESZ_W-1:0] esz_i,
  output flt_e             flt_o
);
  logic             fpu_active;
  logic [ESZ_W-1:0] esz_eff;
  logic             undef_c;

  always_comb begin
    fpu_active = fpu_en_i & ~lazy_i & ~newctx_i;
    esz_eff    = fpu_active ? esz_i : ESZ_DFLT;
    undef_c    = ~lob_i | (forever_i & tailpred_i) | in_cond_i | (tailpred_i & ~vec_i);
    if (undef_c)                                      flt_o = FLT_UNDEF;
    else if (tailpred_i && !fpu_en_i)                 flt_o = FLT_FPU;
    else if (!tailpred_i && vec_i && esz_eff != ESZ_DFLT) flt_o = FLT_INVST;
    else                                              flt_o = FLT_NONE;
  end
endmodule

// File: rtl/loop_end_step.sv
module loop_end_step
  import loop_end_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFS_W = 12
) (
  input  logic             forever_i,
  input  logic             tailpred_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic [XLEN-1:0]  count_i,
  input  logic [ESZ_W-1:0] esz_i,
  output logic             taken_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic [XLEN-1:0]  count_o,
  output logic             exit_tp_o
);
  localparam logic [XLEN-1:0] ONE  = XLEN'(1);
  localparam logic [XLEN-1:0] INSN = XLEN'(4);

  logic [ESZ_W-1:0] shamt;
  logic [XLEN-1:0]  step;
  logic [XLEN-1:0]  back_pc;

  always_comb begin
    shamt   = tailpred_i ? (ESZ_DFLT - esz_i) : '0;
    step    = ONE << shamt;
    back_pc = pc_i - XLEN'(offset_i);
    taken_o   = 1'b1;
    next_pc_o = back_pc;
    count_o   = count_i;
    exit_tp_o = 1'b0;
    if (!forever_i) begin
      if (count_i <= step) begin
        taken_o   = 1'b0;
        next_pc_o = pc_i + INSN;
        exit_tp_o = tailpred_i;
      end else begin
        count_o = count_i - step;
      end
    end
  end
endmodule

// File: rtl/loop_end_esz_reg.sv
module loop_end_esz_reg
  import loop_end_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [ESZ_W-1:0] wr_data_i,
  input  logic             exit_rst_i,
  output logic [ESZ_W-1:0] esz_o
);
  logic [ESZ_W-1:0] esz_q, esz_d;
  logic             esz_en;

  always_comb begin
    esz_en = exit_rst_i | (wr_en_i & (wr_data_i <= ESZ_DFLT));
    esz_d  = exit_rst_i ? ESZ_DFLT : wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      esz_q <= ESZ_DFLT;
    else if (esz_en) esz_q <= esz_d;
  end

  assign esz_o = esz_q;
endmodule

// File: rtl/loop_end_unit.sv
module loop_end_unit
  import loop_end_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_forever,
  input  logic             req_tailpred,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [XLEN-1:0]  req_pc,
  input  logic [XLEN-1:0]  req_count,
  input  logic             lob_present,
  input  logic             vec_present,
  input  logic             fpu_enabled,
  input  logic             fpu_lazy_pend,
  input  logic             fpu_new_ctx,
  input  logic             in_cond_block,
  input  logic             esz_wr_en,
  input  logic [2:0]       esz_wr_data,
  output logic [2:0]       esz_q,
  output logic             rsp_valid,
  output logic             rsp_taken,
  output logic [XLEN-1:0]  rsp_next_pc,
  output logic [XLEN-1:0]  rsp_count,
  output logic             rsp_undef,
  output logic             rsp_fpu_fault,
  output logic             rsp_inv_state
);
  logic [1:0]      rst_pipe;
  logic            rst_sn;
  flt_e            flt;
  logic            fault;
  logic            st_taken, st_exit_tp;
  logic [XLEN-1:0] st_next_pc, st_count;
  logic            exit_rst;

  logic            taken_d, undef_d, fpu_d, inv_d;
  logic [XLEN-1:0] next_pc_d, count_d;
  logic            valid_q, taken_q, undef_q, fpu_q, inv_q;
  logic [XLEN-1:0] next_pc_q, count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  loop_end_classify u_classify (
    .forever_i (req_forever),
    .tailpred_i(req_tailpred),
    .in_cond_i (in_cond_block),
    .lob_i     (lob_present),
    .vec_i     (vec_present),
    .fpu_en_i  (fpu_enabled),
    .lazy_i    (fpu_lazy_pend),
    .newctx_i  (fpu_new_ctx),
    .esz_i     (esz_q),
    .flt_o     (flt)
  );

  loop_end_step #(.XLEN(XLEN), .OFS_W(OFS_W)) u_step (
    .forever_i (req_forever),
    .tailpred_i(req_tailpred),
    .pc_i      (req_pc),
    .offset_i  (req_offset),
    .count_i   (req_count),
    .esz_i     (esz_q),
    .taken_o   (st_taken),
    .next_pc_o (st_next_pc),
    .count_o   (st_count),
    .exit_tp_o (st_exit_tp)
  );

  loop_end_esz_reg u_esz (
    .clk       (clk),
    .rst_n     (rst_sn),
    .wr_en_i   (esz_wr_en),
    .wr_data_i (esz_wr_data),
    .exit_rst_i(exit_rst),
    .esz_o     (esz_q)
  );

  always_comb begin
    fault     = (flt != FLT_NONE);
    exit_rst  = req_valid & ~fault & st_exit_tp;
    taken_d   = ~fault & st_taken;
    next_pc_d = fault ? req_pc : st_next_pc;
    count_d   = fault ? req_count : st_count;
    undef_d   = (flt == FLT_UNDEF);
    fpu_d     = (flt == FLT_FPU);
    inv_d     = (flt == FLT_INVST);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) valid_q <= 1'b0;
    else         valid_q <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      taken_q   <= 1'b0;
      next_pc_q <= '0;
      count_q   <= '0;
      undef_q   <= 1'b0;
      fpu_q     <= 1'b0;
      inv_q     <= 1'b0;
    end else if (req_valid) begin
      taken_q   <= taken_d;
      next_pc_q <= next_pc_d;
      count_q   <= count_d;
      undef_q   <= undef_d;
      fpu_q     <= fpu_d;
      inv_q     <= inv_d;
    end
  end

  assign rsp_valid     = valid_q;
  assign rsp_taken     = taken_q;
  assign rsp_next_pc   = next_pc_q;
  assign rsp_count     = count_q;
  assign rsp_undef     = undef_q;
  assign rsp_fpu_fault = fpu_q;
  assign rsp_inv_state = inv_q;
endmodule

// File: rtl/loop_end_unit_chk.sv
module loop_end_unit_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFS_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_forever,
  input logic            req_tailpred,
  input logic [XLEN-1:0] req_pc,
  input logic [XLEN-1:0] req_count,
  input logic [2:0]      esz_q,
  input logic            rsp_valid,
  input logic            rsp_taken,
  input logic [XLEN-1:0] rsp_next_pc,
  input logic [XLEN-1:0] rsp_count,
  input logic            rsp_undef,
  input logic            rsp_fpu_fault,
  input logic            rsp_inv_state
);
  logic any_fault;
  assign any_fault = rsp_undef | rsp_fpu_fault | rsp_inv_state;

  // R1: one response per request, one cycle later
  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R4: faults are exclusive
  assert_fault_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0({rsp_undef, rsp_fpu_fault, rsp_inv_state}));

  // R4: a faulting response passes the request state through
  assert_fault_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && any_fault) |->
      (!rsp_taken && rsp_count == $past(req_count) && rsp_next_pc == $past(req_pc)));

  // R7: infinite form always branches and keeps the counter
  assert_forever_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !any_fault && $past(req_forever)) |->
      (rsp_taken && rsp_count == $past(req_count)));

  // R8: a counted branch always lowers the counter
  assert_taken_lowers_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_taken && !$past(req_forever)) |-> (rsp_count < $past(req_count)));

  // R10: tail-predicated fall-through restores the default size
  assert_tp_exit_restores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_taken && !any_fault && $past(req_tailpred)) |-> (esz_q == 3'd4));

  // R12: element size stays in its legal range
  assert_esz_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    esz_q <= 3'd4);
endmodule

bind loop_end_unit loop_end_unit_chk #(.XLEN(XLEN), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/loop_end_unit_bench.sv
module loop_end_unit_bench;
  localparam int XLEN  = 32;
  localparam int OFS_W = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_forever, req_tailpred;
  logic [OFS_W-1:0] req_offset;
  logic [XLEN-1:0] req_pc, req_count;
  logic lob_present, vec_present, fpu_enabled, fpu_lazy_pend, fpu_new_ctx, in_cond_block;
  logic esz_wr_en;
  logic [2:0] esz_wr_data;
  logic [2:0] esz_q;
  logic rsp_valid, rsp_taken, rsp_undef, rsp_fpu_fault, rsp_inv_state;
  logic [XLEN-1:0] rsp_next_pc, rsp_count;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  // behavioural model state
  int unsigned m_esz;
  bit e_valid, e_taken, e_undef, e_fpu, e_inv;
  logic [XLEN-1:0] e_pc, e_cnt;

  always #4 clk = ~clk;

  loop_end_unit #(.XLEN(XLEN), .OFS_W(OFS_W)) u_loop_end_unit (.*);

  task automatic chk(input string tag, input longint got, input longint exp);
    n_vec++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic setreq(input bit fv, input bit tp, input logic [XLEN-1:0] pc,
                        input logic [OFS_W-1:0] off, input logic [XLEN-1:0] cnt);
    req_valid = 1; req_forever = fv; req_tailpred = tp;
    req_pc = pc; req_offset = off; req_count = cnt;
  endtask

  task automatic defaults();
    lob_present = 1; vec_present = 1; fpu_enabled = 1;
    fpu_lazy_pend = 0; fpu_new_ctx = 0; in_cond_block = 0;
  endtask

  task automatic predict();
    bit active, exit_tp;
    int unsigned eff;
    longint unsigned step;
    e_valid = req_valid; e_taken = 0; e_undef = 0; e_fpu = 0; e_inv = 0;
    e_pc = req_pc; e_cnt = req_count; exit_tp = 0;
    if (req_valid) begin
      active = fpu_enabled && !fpu_lazy_pend && !fpu_new_ctx;
      eff = active ? m_esz : 4;
      if (!lob_present || (req_forever && req_tailpred) || in_cond_block ||
          (req_tailpred && !vec_present)) e_undef = 1;
      else if (req_tailpred && !fpu_enabled) e_fpu = 1;
      else if (!req_tailpred && vec_present && eff != 4) e_inv = 1;
      if (!(e_undef || e_fpu || e_inv)) begin
        if (req_forever) begin
          e_taken = 1; e_pc = req_pc - {{(XLEN-OFS_W){1'b0}}, req_offset};
        end else begin
          step = req_tailpred ? (64'd1 << (4 - m_esz)) : 64'd1;
          if (longint'(req_count) <= step) begin
            e_pc = req_pc + 32'd4; exit_tp = req_tailpred;
          end else begin
            e_taken = 1; e_pc = req_pc - {{(XLEN-OFS_W){1'b0}}, req_offset};
            e_cnt = req_count - XLEN'(step);
          end
        end
      end
    end
    if (exit_tp) m_esz = 4;
    else if (esz_wr_en && esz_wr_data <= 3'd4) m_esz = esz_wr_data;
  endtask

  task automatic tick(input string tag);
    predict();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " valid"}, rsp_valid, e_valid);
    chk({tag, " esz"}, esz_q, m_esz);
    if (e_valid) begin
      chk({tag, " taken"}, rsp_taken, e_taken);
      chk({tag, " pc"}, rsp_next_pc, e_pc);
      chk({tag, " count"}, rsp_count, e_cnt);
      chk({tag, " undef"}, rsp_undef, e_undef);
      chk({tag, " fpu"}, rsp_fpu_fault, e_fpu);
      chk({tag, " inv"}, rsp_inv_state, e_inv);
    end
    req_valid = 0; esz_wr_en = 0;
  endtask

  task automatic wr_esz(input logic [2:0] v, input string tag);
    esz_wr_en = 1; esz_wr_data = v;
    tick(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_forever = 0; req_tailpred = 0;
    req_offset = '0; req_pc = '0; req_count = '0;
    esz_wr_en = 0; esz_wr_data = '0; m_esz = 4;
    defaults();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset esz", esz_q, 4);
    chk("R1 reset valid", rsp_valid, 0);

    // R8 plain counting and boundaries
    setreq(0, 0, 32'h1000, 12'h20, 5); tick("R8 count5");
    setreq(0, 0, 32'h1000, 12'h20, 2); tick("R8 count2");
    setreq(0, 0, 32'h1000, 12'h20, 1); tick("R8 count1");
    setreq(0, 0, 32'h1000, 12'h20, 0); tick("R8 count0");
    setreq(0, 0, 32'h1000, 12'h20, 32'hFFFF_FFFF); tick("R8 countmax");
    // R7 infinite
    setreq(1, 0, 32'h2000, 12'hFFF, 0); tick("R7 forever");
    tick("R1 idle");
    // R2 undefined sources
    setreq(1, 1, 32'h3000, 12'h10, 9); tick("R2 bothflags");
    in_cond_block = 1; setreq(0, 0, 32'h3000, 12'h10, 9); tick("R2 condblk"); defaults();
    lob_present = 0; setreq(1, 0, 32'h3000, 12'h10, 9); tick("R2 nolob"); defaults();
    vec_present = 0; setreq(0, 1, 32'h3000, 12'h10, 9); tick("R2 novec"); defaults();
    // R3 / R4 priority
    fpu_enabled = 0; setreq(0, 1, 32'h3000, 12'h10, 9); tick("R3 fpuoff");
    in_cond_block = 1; setreq(0, 1, 32'h3000, 12'h10, 9); tick("R4 undef_over_fpu"); defaults();
    // R9 / R10 tail-predicated
    wr_esz(3'd2, "R11 write2");
    setreq(0, 1, 32'h4000, 12'h40, 10); tick("R9 esz2_step4");
    setreq(0, 1, 32'h4000, 12'h40, 5);  tick("R9 esz2_above");
    setreq(0, 1, 32'h4000, 12'h40, 4);  tick("R10 esz2_exit");
    wr_esz(3'd0, "R11 write0");
    setreq(0, 1, 32'h4000, 12'h40, 17); tick("R9 esz0_17");
    setreq(0, 1, 32'h4000, 12'h40, 16); tick("R10 esz0_exit");
    setreq(0, 1, 32'h4000, 12'h40, 2);  tick("R9 esz4_step1");
    // R6 / R5 plain with non-default size
    wr_esz(3'd2, "R11 write2b");
    setreq(0, 0, 32'h5000, 12'h8, 5); tick("R6 invstate");
    vec_present = 0; setreq(0, 0, 32'h5000, 12'h8, 5); tick("R6 novec"); defaults();
    fpu_lazy_pend = 1; setreq(0, 0, 32'h5000, 12'h8, 5); tick("R5 lazy"); defaults();
    fpu_new_ctx = 1; setreq(0, 0, 32'h5000, 12'h8, 5); tick("R5 newctx"); defaults();
    fpu_enabled = 0; setreq(1, 0, 32'h5000, 12'h8, 5); tick("R5 fpuoff_plain"); defaults();
    fpu_lazy_pend = 1; setreq(0, 1, 32'h5000, 12'h8, 10); tick("R5 tp_lazy"); defaults();
    // R11 illegal writes and collision
    wr_esz(3'd1, "R11 write1");
    wr_esz(3'd5, "R11 write5");
    wr_esz(3'd7, "R11 write7");
    esz_wr_en = 1; esz_wr_data = 3'd3;
    setreq(0, 1, 32'h6000, 12'h4, 1); tick("R11 collide");

    // R9 random mix
    for (int i = 0; i < 400; i++) begin
      lob_present   = ($urandom_range(0, 15) != 0);
      vec_present   = ($urandom_range(0, 7) != 0);
      fpu_enabled   = ($urandom_range(0, 7) != 0);
      fpu_lazy_pend = ($urandom_range(0, 5) == 0);
      fpu_new_ctx   = ($urandom_range(0, 5) == 0);
      in_cond_block = ($urandom_range(0, 15) == 0);
      esz_wr_en     = ($urandom_range(0, 3) == 0);
      esz_wr_data   = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 4) != 0)
        setreq(($urandom_range(0, 7) == 0), $urandom_range(0, 1) == 1,
               $urandom, 12'($urandom), XLEN'($urandom_range(0, 40)));
      tick("R9 random");
    end
    defaults();
    tick("R1 final idle");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule